// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Controller

This block drives the fine-tuning mode of a bank of digitally set wiper codes. The serial front end raises a one-cycle arm request when it has acknowledged the instruction byte that opens a stepping sequence, and it passes along the two-bit channel select taken from that byte. From then on, the two-wire bus carries no bytes and gets no acknowledges. Each high period of the serial clock is one step of the selected wiper. The level of the data line at the rising clock edge sets the direction: high steps the code up and low steps it down.

The step is committed only when the serial clock falls again, and only if the data line stayed steady while the clock was high. This keeps the closing STOP of a sequence, and any START that cuts into it, from causing an extra step. A STOP or START report from the front end disarms the block. It reads the current code of every channel from the register bank so that it can hold a code at its end points. Its single-cycle up and down strobes, with a channel index, are the only way it changes the bank.

Top module: `wstep_top`

## Requirements
- R1: Out of reset the block is disarmed, and both strobes are low. Serial clock pulses before the first arm request produce no strobe.
- R2: An arm request latches `armChan`, and every later strobe carries that channel on `stepChan` until the next arm request. Only that channel's code changes.
- R3: When the block is armed and the data line is 1 at a serial clock rise, one `stepUp` strobe is issued as that high period ends.
- R4: When the block is armed and the data line is 0 at a serial clock rise, one `stepDown` strobe is issued as that high period ends.
- R5: Each serial clock high period gives at most one strobe, one system clock cycle wide. It is visible after the first system clock edge that samples the serial clock low, and the two strobes are never high together.
- R6: No `stepUp` is issued while the selected code is all ones (0xFF at the default 8-bit width).
- R7: No `stepDown` is issued while the selected code is 0x00.
- R8: A `stopSeen` pulse disarms the block, and later clock pulses give no strobe until the next arm request.
- R9: A `startSeen` pulse disarms the block in the same way as R8.
- R10: If the data line changes while the serial clock is high, that high period gives no strobe, and the block stays armed for the next one.
- R11: Up and down pulses may be mixed in any order and number within one armed sequence. A new arm request moves stepping to a new channel.
- R12: A serial clock high period that is already in progress when the arm request arrives gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclSync | input | 1 | Serial clock, already synchronised to clk |
| sdaSync | input | 1 | Serial data line, already synchronised to clk |
| armReq | input | 1 | One-cycle pulse: stepping instruction acknowledged |
| armChan | input | CH_W (2) | Channel select that comes with armReq |
| stopSeen | input | 1 | One-cycle pulse: STOP detected by the front end |
| startSeen | input | 1 | One-cycle pulse: START detected by the front end |
| wiperCodes | input | NUM_CH*CODE_W (32) | Current codes of all channels, channel 0 in the low bits |
| stepUp | output | 1 | One-cycle strobe: add one to channel stepChan |
| stepDown | output | 1 | One-cycle strobe: subtract one from channel stepChan |
| stepChan | output | CH_W (2) | Channel addressed by the strobes |

## Verification
The assertions take for granted that the front end's arm, STOP and START reports are single-cycle pulses. They also take for granted that `wiperCodes` reflects each strobe before the next serial clock high period ends, and that the synchronised bus lines are free of glitches. The bench models the register bank itself and applies each strobe at once. It holds every bus level for several system clock cycles, and it changes the data line while the serial clock is high only in the scenarios that mean to do so (STOP, START and a cancelled pulse).

// File: rtl/wstep_pkg.sv
package wstep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_PULSE,
    ST_VOID
  } stepStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch channel select
    logic capture;  // latch step direction from the data line
    logic commit;   // issue the step (end of a clean high period)
  } stepCmdT;

endpackage

// File: rtl/wstep_ctrl.sv
module wstep_ctrl
  import wstep_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclSync,
  input  logic    sdaSync,
  input  logic    armReq,
  input  logic    stopSeen,
  input  logic    startSeen,
  output stepCmdT cmd
);

  stepStateT state, nxtState;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, sdaHiEdge;

  assign sclRise   = sclSync & ~sclPrev;
  assign sclFall   = ~sclSync & sclPrev;
  assign sdaHiEdge = sclSync & sclPrev & (sdaSync != sdaPrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      state   <= nxtState;
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  always_comb begin
    cmd      = '0;
    nxtState = state;
    if (stopSeen || startSeen) begin
      nxtState = ST_IDLE;
    end else if (armReq) begin
      cmd.load = 1'b1;
      nxtState = ST_ARMED;
    end else begin
      unique case (state)
        ST_ARMED: if (sclRise) begin
          cmd.capture = 1'b1;
          nxtState    = ST_PULSE;
        end
        ST_PULSE: if (sdaHiEdge) begin
          nxtState = ST_VOID;
        end else if (sclFall) begin
          cmd.commit = 1'b1;
          nxtState   = ST_ARMED;
        end
        ST_VOID: if (sclFall) nxtState = ST_ARMED;
        default: ;
      endcase
    end
  end

  // R5: a commit always returns to ARMED, so two in a row cannot happen
  p_single_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> !cmd.commit);

  // R8: STOP leaves the block disarmed
  p_stop_disarms_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE));

  // R9: START leaves the block disarmed
  p_start_disarms_r9: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_IDLE));

  // R10: a data edge during a high period voids that period
  p_edge_voids_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && sdaHiEdge && !armReq && !stopSeen && !startSeen)
      |=> (state == ST_VOID));

  // R1: no commit while disarmed
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !cmd.commit);

endmodule

// File: rtl/wstep_dp.sv
module wstep_dp
  import wstep_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stepCmdT                  cmd,
  input  logic                     sdaSync,
  input  logic [CH_W-1:0]          armChan,
  input  logic [NUM_CH*CODE_W-1:0] wiperCodes,
  output logic                     stepUp,
  output logic                     stepDown,
  output logic [CH_W-1:0]          stepChan
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] codeArr [NUM_CH];
  logic [CODE_W-1:0] selCode;
  logic [CH_W-1:0]   chanQ;
  logic              dirUpQ;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign codeArr[g] = wiperCodes[g*CODE_W +: CODE_W];
  end

  assign selCode = codeArr[chanQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ    <= '0;
      dirUpQ   <= 1'b0;
      stepUp   <= 1'b0;
      stepDown <= 1'b0;
      stepChan <= '0;
    end else begin
      if (cmd.load)    chanQ  <= armChan;
      if (cmd.capture) dirUpQ <= sdaSync;
      stepUp   <= cmd.commit & dirUpQ  & (selCode != CODE_MAX);
      stepDown <= cmd.commit & ~dirUpQ & (selCode != CODE_MIN);
      if (cmd.commit)  stepChan <= chanQ;
    end
  end

  // R5: never both directions at once
  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stepUp && stepDown));

  // R6: no up step from the top code
  p_sat_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    stepUp |-> ($past(selCode) != CODE_MAX));

  // R7: no down step from the bottom code
  p_sat_down_r7: assert property (@(posedge clk) disable iff (!rstN)
    stepDown |-> ($past(selCode) != CODE_MIN));

  // R2: strobes address the latched channel
  p_chan_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stepUp || stepDown) |-> (stepChan == chanQ));

endmodule

// File: rtl/wstep_top.sv
module wstep_top
  import wstep_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclSync,
  input  logic                     sdaSync,
  input  logic                     armReq,
  input  logic [CH_W-1:0]          armChan,
  input  logic                     stopSeen,
  input  logic                     startSeen,
  input  logic [NUM_CH*CODE_W-1:0] wiperCodes,
  output logic                     stepUp,
  output logic                     stepDown,
  output logic [CH_W-1:0]          stepChan
);

  stepCmdT cmd;

  wstep_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclSync   (sclSync),
    .sdaSync   (sdaSync),
    .armReq    (armReq),
    .stopSeen  (stopSeen),
    .startSeen (startSeen),
    .cmd       (cmd)
  );

  wstep_dp #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .CH_W   (CH_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .sdaSync    (sdaSync),
    .armChan    (armChan),
    .wiperCodes (wiperCodes),
    .stepUp     (stepUp),
    .stepDown   (stepDown),
    .stepChan   (stepChan)
  );

endmodule

// File: tb/tb_wstep_top.sv
module tb_wstep_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic armReq = 1'b0, stopSeen = 1'b0, startSeen = 1'b0;
  logic [1:0] armChan = '0;
  logic [31:0] wiperCodes;
  logic stepUp, stepDown;
  logic [1:0] stepChan;

  logic [7:0] bank [4];
  int upCnt = 0, dnCnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wstep_top dut (
    .clk(clk), .rstN(rstN), .sclSync(scl), .sdaSync(sda),
    .armReq(armReq), .armChan(armChan), .stopSeen(stopSeen),
    .startSeen(startSeen), .wiperCodes(wiperCodes),
    .stepUp(stepUp), .stepDown(stepDown), .stepChan(stepChan)
  );

  always_comb wiperCodes = {bank[3], bank[2], bank[1], bank[0]};

  // register bank model: applies strobes, wraps so a bad step is visible
  always @(negedge clk) begin
    if (stepUp)   begin upCnt++; bank[stepChan] = bank[stepChan] + 8'd1; end
    if (stepDown) begin dnCnt++; bank[stepChan] = bank[stepChan] - 8'd1; end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    scl = 1'b0; waitc(2);
    sda = d;    waitc(3);
    scl = 1'b1; waitc(3);
    scl = 1'b0; waitc(3);
  endtask

  task automatic arm(input logic [1:0] ch);
    armChan = ch; armReq = 1'b1; waitc(1);
    armReq = 1'b0; waitc(2);
  endtask

  task automatic t_reset;
    int u0, d0;
    check("R1 stepUp after reset", stepUp, 0);
    check("R1 stepDown after reset", stepDown, 0);
    u0 = upCnt; d0 = dnCnt;
    pulse(1); pulse(0); pulse(1);
    check("R1 no strobe before arm", (upCnt - u0) + (dnCnt - d0), 0);
  endtask

  task automatic t_up;
    int u0;
    bank[2] = 8'd10; bank[0] = 8'd50;
    u0 = upCnt;
    arm(2'd2);
    repeat (5) pulse(1);
    check("R3 up count", upCnt - u0, 5);
    check("R3 code after ups", bank[2], 15);
    check("R2 other channel untouched", bank[0], 50);
  endtask

  task automatic t_down;
    bank[1] = 8'd20;
    arm(2'd1);
    repeat (3) pulse(0);
    check("R4 code after downs", bank[1], 17);
  endtask

  task automatic t_timing;
    arm(2'd0);
    scl = 1'b0; waitc(2);
    sda = 1'b1; waitc(3);
    scl = 1'b1; waitc(3);
    scl = 1'b0;
    @(negedge clk);
    check("R5 strobe one edge after fall", stepUp, 1);
    check("R5 strobe channel", stepChan, 0);
    @(negedge clk);
    check("R5 strobe one cycle wide", stepUp, 0);
    waitc(3);
  endtask

  task automatic t_mixed;
    logic [9:0] pat = 10'b1110001011;
    bank[3] = 8'd100; bank[0] = 8'd7;
    arm(2'd3);
    for (int i = 0; i < 10; i++) pulse(pat[i]);
    check("R11 mixed sequence result", bank[3], 102);
    arm(2'd0);
    pulse(1);
    check("R11 rearmed channel moved", bank[0], 8);
    check("R11 old channel held", bank[3], 102);
  endtask

  task automatic t_sat_up;
    int u0;
    bank[1] = 8'd254;
    u0 = upCnt;
    arm(2'd1);
    repeat (3) pulse(1);
    check("R6 code held at top", bank[1], 255);
    check("R6 single up issued", upCnt - u0, 1);
  endtask

  task automatic t_sat_down;
    int d0;
    bank[2] = 8'd1;
    d0 = dnCnt;
    arm(2'd2);
    repeat (3) pulse(0);
    check("R7 code held at bottom", bank[2], 0);
    check("R7 single down issued", dnCnt - d0, 1);
  endtask

  task automatic t_void;
    bank[0] = 8'd30;
    arm(2'd0);
    scl = 1'b0; waitc(2);
    sda = 1'b1; waitc(3);
    scl = 1'b1; waitc(3);
    sda = 1'b0; waitc(3);   // edge while high, no START reported
    scl = 1'b0; waitc(3);
    check("R10 voided pulse gives no step", bank[0], 30);
    pulse(1);
    check("R10 still armed afterwards", bank[0], 31);
  endtask

  task automatic t_stop;
    int u0, d0;
    bank[2] = 8'd40;
    arm(2'd2);
    pulse(1);
    scl = 1'b0; waitc(2);
    sda = 1'b0; waitc(3);
    scl = 1'b1; waitc(3);
    sda = 1'b1; stopSeen = 1'b1; waitc(1);
    stopSeen = 1'b0; waitc(3);
    check("R10 no step on STOP edge", bank[2], 41);
    u0 = upCnt; d0 = dnCnt;
    pulse(1); pulse(0);
    check("R8 disarmed after STOP", (upCnt - u0) + (dnCnt - d0), 0);
  endtask

  task automatic t_start;
    int u0, d0;
    arm(2'd1);
    scl = 1'b1; waitc(2);
    sda = 1'b0; startSeen = 1'b1; waitc(1);
    startSeen = 1'b0; waitc(3);
    u0 = upCnt; d0 = dnCnt;
    pulse(1); pulse(0);
    check("R9 disarmed after START", (upCnt - u0) + (dnCnt - d0), 0);
  endtask

  task automatic t_arm_high;
    bank[3] = 8'd60;
    scl = 1'b0; waitc(2);
    sda = 1'b1; waitc(2);
    scl = 1'b1; waitc(2);
    arm(2'd3);
    scl = 1'b0; waitc(3);
    check("R12 open high period ignored", bank[3], 60);
    pulse(1);
    check("R12 next period steps", bank[3], 61);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bank[i] = 8'd128;
    waitc(5);
    rstN = 1'b1;
    waitc(2);
    t_reset();
    t_up();
    t_down();
    t_timing();
    t_mixed();
    t_sat_up();
    t_sat_down();
    t_void();
    t_stop();
    t_start();
    t_arm_high();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule